// File: doc/BRIEF.md
# Multicycle Displacement-Load Sequencer

This block is a small multicycle control unit with its own datapath. It runs a stream of instructions out of a synchronous memory. It keeps three registers: a program counter, a base index register and a word-wide accumulator. It has one address bus and one read-data bus, and it makes at most one memory read per cycle. It never writes to memory.

A displacement load runs in four steps:

1. The counter's value goes out as the address of the opcode.
2. The counter's value goes out again, this time as the address of the displacement word.
3. The sum of the index register and the displacement goes straight onto the address bus. No address latch sits between the adder and the bus.
4. The returned word is written into the accumulator.

Each counter increment happens in the same cycle as the next bus step, so it costs no cycle of its own. A no-operation opcode takes two cycles. Any other opcode stops the sequencer until reset.

The `run_i` input is sampled only at an instruction boundary. While it is low at a boundary, the sequencer is idle and no read is issued. Only then does the index-register test port take a write. The memory is expected to return data one cycle after the address and read strobe are presented.

Top module: `disp_load_seq`

## Requirements
- R1: While `rst_n` is low, `pc_o` and `acc_o` are zero, and `done_o`, `illegal_o` and `mem_rd_o` are low. The index register is cleared to zero, and the sequencer restarts at an instruction boundary.
- R2: At an instruction boundary with `run_i` high and no halt, `mem_rd_o` is high and `mem_addr_o` equals `pc_o`. This is the opcode fetch.
- R3: `pc_o` only ever changes by adding one. It advances on the clock edge that ends each opcode fetch and each displacement fetch, with no cycle spent on the increment alone.
- R4: The opcode is bits [7:0] of `mem_rdata_i` in the cycle after the opcode fetch. If it is 8'h8B, then in that same cycle `mem_rd_o` is high and `mem_addr_o` equals the already-advanced `pc_o`. This is the displacement fetch.
- R5: In the cycle after the displacement fetch, `mem_rd_o` is high. `mem_addr_o` equals the index register plus bits [ADDR_W-1:0] of `mem_rdata_i`, modulo 2^ADDR_W, in that same cycle.
- R6: The word returned for that address is written into the accumulator. `acc_o` shows it and `done_o` is high for exactly one cycle, four cycles after the load's opcode fetch. That cycle is also the next instruction boundary. `acc_o` changes at no other time.
- R7: Opcode 8'h90 issues no read in its decode cycle and leaves the accumulator unchanged. The next boundary follows two cycles after its opcode fetch, with `pc_o` advanced by one.
- R8: Any other opcode sets `illegal_o` from the next cycle on until reset. While it is set, no read is issued, `pc_o` holds and `busy_o` is low.
- R9: A write through `idx_we_i`/`idx_wdata_i` loads the index register only in an idle cycle. An idle cycle is a boundary with `run_i` low and no halt. A write in any other cycle is ignored.
- R10: At a boundary with `run_i` low, no read is issued and `busy_o` is low. `busy_o` is high in every cycle of an instruction in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Allow a new instruction to start at a boundary |
| idx_we_i | input | 1 | Test-port write strobe for the index register |
| idx_wdata_i | input | ADDR_W | Test-port value for the index register |
| mem_addr_o | output | ADDR_W | Memory address bus |
| mem_rd_o | output | 1 | Read strobe; data is due one cycle later |
| mem_rdata_i | input | DATA_W | Memory read-data bus |
| acc_o | output | DATA_W | Accumulator |
| pc_o | output | ADDR_W | Program counter |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle pulse when an accumulator load is visible |
| illegal_o | output | 1 | Sticky illegal-opcode halt flag |

## Verification
A load's bus activity falls on fixed cycles after its opcode fetch:

| Cycle after opcode fetch | Due |
|---|---|
| 1 | Displacement address |
| 2 | Combinational effective address |
| 4 | New accumulator value and `done_o` |

A no-operation returns to a boundary two cycles after its fetch. An illegal opcode shows `illegal_o` two cycles after its fetch. The bench steps a behavioural model that keeps a step counter and a memory array. It drives inputs just after the falling edge and compares every output one time unit later. That way each registered result is sampled in the cycle it becomes due, and the combinational address is sampled in the cycle it is driven. Index writes are sent both in idle and in busy or halted cycles. The effective addresses of later loads show whether each write took effect.

// File: rtl/dls_pkg.sv
package dls_pkg;

  localparam int unsigned OPC_W    = 8;
  localparam logic [OPC_W-1:0] OPC_LOAD = 8'h8B;
  localparam logic [OPC_W-1:0] OPC_NOP  = 8'h90;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_OPER  = 2'd1,
    ST_EADDR = 2'd2,
    ST_WBACK = 2'd3
  } step_e;

  typedef enum logic [1:0] {
    OPK_LOAD = 2'd0,
    OPK_NOP  = 2'd1,
    OPK_BAD  = 2'd2
  } opk_e;

endpackage

// File: rtl/dls_decode.sv
module dls_decode
  import dls_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  output opk_e             kind_o
);

  always_comb begin
    unique case (opc_i)
      OPC_LOAD: kind_o = OPK_LOAD;
      OPC_NOP:  kind_o = OPK_NOP;
      default:  kind_o = OPK_BAD;
    endcase
  end

endmodule

// File: rtl/dls_pc.sv
module dls_pc #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] pc_o
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (inc_i) pc_q <= pc_q + ONE;
  end

  assign pc_o = pc_q;

  // R3: the counter moves only forward by one
  p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_q != $past(pc_q)) |-> (pc_q == $past(pc_q) + ONE));

endmodule

// File: rtl/dls_agu.sv
module dls_agu #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] disp_i,
  output logic [ADDR_W-1:0] ea_o
);

  logic [ADDR_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (load_i) idx_q <= wdata_i;
  end

  // The adder feeds the bus directly, with no latch stage between them.
  assign ea_o = idx_q + disp_i;

  // R9: the index register holds unless a granted write arrives
  p_idx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(idx_q));

endmodule

// File: rtl/dls_ctrl.sv
module dls_ctrl
  import dls_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run_i,
  input  logic  idx_we_i,
  input  opk_e  kind_i,
  output step_e state_o,
  output logic  rd_o,
  output logic  pc_inc_o,
  output logic  sel_ea_o,
  output logic  acc_we_o,
  output logic  idx_load_o,
  output logic  busy_o,
  output logic  done_o,
  output logic  illegal_o
);

  step_e state_q, state_d;
  logic  halt_q, halt_d;
  logic  done_q;
  logic  idle;

  assign idle = (state_q == ST_FETCH) && !run_i && !halt_q;

  always_comb begin
    state_d  = state_q;
    halt_d   = halt_q;
    rd_o     = 1'b0;
    pc_inc_o = 1'b0;
    sel_ea_o = 1'b0;
    acc_we_o = 1'b0;
    unique case (state_q)
      ST_FETCH: begin
        if (!halt_q && run_i) begin
          rd_o     = 1'b1;
          pc_inc_o = 1'b1;
          state_d  = ST_OPER;
        end
      end
      ST_OPER: begin
        unique case (kind_i)
          OPK_LOAD: begin
            rd_o     = 1'b1;
            pc_inc_o = 1'b1;
            state_d  = ST_EADDR;
          end
          OPK_NOP: state_d = ST_FETCH;
          default: begin
            halt_d  = 1'b1;
            state_d = ST_FETCH;
          end
        endcase
      end
      ST_EADDR: begin
        rd_o     = 1'b1;
        sel_ea_o = 1'b1;
        state_d  = ST_WBACK;
      end
      ST_WBACK: begin
        acc_we_o = 1'b1;
        state_d  = ST_FETCH;
      end
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      halt_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      halt_q  <= halt_d;
      done_q  <= acc_we_o;
    end
  end

  assign state_o    = state_q;
  assign idx_load_o = idx_we_i && idle;
  assign busy_o     = !((state_q == ST_FETCH) && (halt_q || !run_i));
  assign done_o     = done_q;
  assign illegal_o  = halt_q;

  // R6: completion is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: a halt persists until reset
  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |=> illegal_o);

  // R8: a halted sequencer issues no reads
  p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !rd_o);

endmodule

// File: rtl/disp_load_seq.sv
module disp_load_seq
  import dls_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              idx_we_i,
  input  logic [ADDR_W-1:0] idx_wdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              illegal_o
);

  opk_e              kind;
  step_e             state;
  logic              pc_inc, sel_ea, acc_we, idx_load;
  logic [ADDR_W-1:0] pc, ea;
  logic [DATA_W-1:0] acc_q;

  dls_decode u_dec (
    .opc_i  (mem_rdata_i[OPC_W-1:0]),
    .kind_o (kind)
  );

  dls_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run_i),
    .idx_we_i   (idx_we_i),
    .kind_i     (kind),
    .state_o    (state),
    .rd_o       (mem_rd_o),
    .pc_inc_o   (pc_inc),
    .sel_ea_o   (sel_ea),
    .acc_we_o   (acc_we),
    .idx_load_o (idx_load),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .illegal_o  (illegal_o)
  );

  dls_pc #(.ADDR_W(ADDR_W)) u_pc (
    .clk   (clk),
    .rst_n (rst_n),
    .inc_i (pc_inc),
    .pc_o  (pc)
  );

  dls_agu #(.ADDR_W(ADDR_W)) u_agu (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (idx_load),
    .wdata_i (idx_wdata_i),
    .disp_i  (mem_rdata_i[ADDR_W-1:0]),
    .ea_o    (ea)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_we) acc_q <= mem_rdata_i;
  end

  assign mem_addr_o = sel_ea ? ea : pc;
  assign acc_o      = acc_q;
  assign pc_o       = pc;

  // R6: the accumulator changes only after a write-back step
  p_acc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_WBACK) |=> $stable(acc_q));

  // R5: an effective-address read always follows a displacement read
  p_ea_after_disp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && sel_ea) |-> $past(mem_rd_o));

endmodule

// File: tb/disp_load_seq_test.sv
`timescale 1ns/1ps
module disp_load_seq_test;

  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run_i = 1'b0;
  logic          idx_we_i = 1'b0;
  logic [AW-1:0] idx_wdata_i = '0;
  logic [AW-1:0] mem_addr_o;
  logic          mem_rd_o;
  logic [DW-1:0] mem_rdata_i = '0;
  logic [DW-1:0] acc_o;
  logic [AW-1:0] pc_o;
  logic          busy_o, done_o, illegal_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  disp_load_seq #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .idx_we_i(idx_we_i),
    .idx_wdata_i(idx_wdata_i), .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o),
    .mem_rdata_i(mem_rdata_i), .acc_o(acc_o), .pc_o(pc_o), .busy_o(busy_o),
    .done_o(done_o), .illegal_o(illegal_o)
  );

  logic [DW-1:0] mem [256];

  always @(posedge clk) if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];

  // behavioural reference: a step counter walking the instruction
  int            m_step;
  logic [AW-1:0] m_pc, m_idx;
  logic [DW-1:0] m_op, m_disp, m_word, m_acc;
  bit            m_done, m_ill;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_step <= 0; m_pc <= '0; m_idx <= '0; m_acc <= '0;
      m_done <= 1'b0; m_ill <= 1'b0; m_op <= '0; m_disp <= '0; m_word <= '0;
    end else begin
      m_done <= 1'b0;
      case (m_step)
        0: begin
          if (!m_ill && run_i) begin
            m_op <= mem[m_pc]; m_pc <= m_pc + 1'b1; m_step <= 1;
          end else if (!m_ill && idx_we_i) begin
            m_idx <= idx_wdata_i;
          end
        end
        1: begin
          if (m_op[7:0] == 8'h8B) begin
            m_disp <= mem[m_pc]; m_pc <= m_pc + 1'b1; m_step <= 2;
          end else begin
            if (m_op[7:0] != 8'h90) m_ill <= 1'b1;
            m_step <= 0;
          end
        end
        2: begin
          m_word <= mem[AW'(m_idx + m_disp[AW-1:0])]; m_step <= 3;
        end
        default: begin
          m_acc <= m_word; m_done <= 1'b1; m_step <= 0;
        end
      endcase
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    logic          e_rd;
    logic [AW-1:0] e_addr;
    string         t_rd, t_addr;
    case (m_step)
      0: begin e_rd = !m_ill && run_i; e_addr = m_pc; t_rd = "R2/R10 rd"; t_addr = "R2 addr"; end
      1: begin
        e_rd = (m_op[7:0] == 8'h8B); e_addr = m_pc; t_addr = "R4 addr";
        if (m_op[7:0] == 8'h8B) t_rd = "R4 rd";
        else if (m_op[7:0] == 8'h90) t_rd = "R7 rd";
        else t_rd = "R8 rd";
      end
      2: begin e_rd = 1'b1; e_addr = AW'(m_idx + m_disp[AW-1:0]); t_rd = "R5 rd"; t_addr = "R5/R9 addr"; end
      default: begin e_rd = 1'b0; e_addr = '0; t_rd = "R6 rd"; t_addr = ""; end
    endcase
    chk(t_rd, 32'(mem_rd_o), 32'(e_rd));
    if (e_rd) chk(t_addr, 32'(mem_addr_o), 32'(e_addr));
    chk("R3 pc", 32'(pc_o), 32'(m_pc));
    chk("R6/R7 acc", 32'(acc_o), 32'(m_acc));
    chk("R6 done", 32'(done_o), 32'(m_done));
    chk("R8 illegal", 32'(illegal_o), 32'(m_ill));
    chk("R10 busy", 32'(busy_o), 32'(!(m_step == 0 && (m_ill || !run_i))));
  endtask

  task automatic step(input logic run, input logic we, input logic [AW-1:0] wd);
    @(negedge clk);
    run_i = run; idx_we_i = we; idx_wdata_i = wd;
    #1;
    compare_all();
  endtask

  task automatic reset_check();
    @(negedge clk);
    rst_n = 1'b0; run_i = 1'b0; idx_we_i = 1'b0;
    #1;
    chk("R1 pc", 32'(pc_o), 0);
    chk("R1 acc", 32'(acc_o), 0);
    chk("R1 done", 32'(done_o), 0);
    chk("R1 illegal", 32'(illegal_o), 0);
    chk("R1 rd", 32'(mem_rd_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = DW'(i * 16'h0101) ^ 16'h5A3C;
    mem[0] = 16'h008B; mem[1] = 16'h0010;
    mem[2] = 16'hFF90;
    mem[3] = 16'h7E8B; mem[4] = 16'h00F8;
    mem[5] = 16'h0090;
    mem[6] = 16'h008B; mem[7] = 16'hFFFF;
    mem[8] = 16'h0012;

    reset_check();
    step(1'b0, 1'b1, 8'h20);            // R9 idle write accepted
    step(1'b0, 1'b0, '0);
    step(1'b0, 1'b0, '0);
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, '0);
    step(1'b0, 1'b1, 8'h0C);            // R9 idle write accepted
    step(1'b0, 1'b0, '0);
    step(1'b1, 1'b0, '0);
    step(1'b1, 1'b1, 8'h77);            // R9 write while busy ignored
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, '0);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 8'h55); // R8/R9 halted
    reset_check();
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 5000);
    fails++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule